// File: doc/BRIEF.md
# Stream FIFO with Quarter-Band Level Reporting

This block sits inside a DMA stream between the side that produces data items and the side that consumes them. In buffered mode it stores up to `DEPTH` words (four 32-bit words by default), reports how full it is as a 3-bit band code, and raises a drain request once the fill level reaches a threshold chosen in quarters of the capacity. In direct mode the storage is bypassed and each item presented on the write side appears on the read side in the same cycle.

A one-byte configuration register selects buffered or direct mode, picks the threshold and enables the error interrupt. The mode and threshold fields are locked while the stream is enabled. Hardware forces buffered mode whenever an enabled stream is set up for memory-to-memory transfers, because direct mode cannot serve that direction. Writing into a full FIFO or reading from an empty one sets a sticky error flag, and the interrupt enable gates that flag onto the interrupt output.

Top module: `dmaFifo`

## Requirements
- R1: After reset the configuration readback is 0x20 (direct mode, threshold code 00, interrupt disabled, status 100). `fifoStatus` is 100, and `errFlag`, `errIrq` and `drainReq` are 0.
- R2: In buffered mode `fifoStatus` follows the occupancy with one band per quarter of `DEPTH` that is not empty and not full: code 000 below 1/4, 001 from 1/4 up to 1/2, 010 from 1/2 up to 3/4, and 011 from 3/4 up to but not including full. With a depth of four this gives one word → 001, two → 010 and three → 011.
- R3: `fifoStatus` is 100 when the FIFO holds nothing and 101 when it holds `DEPTH` words. Codes 110 and 111 never appear.
- R4: The threshold field (config bits 1:0) selects 1/4 (00), 1/2 (01), 3/4 (10) or full (11). In buffered mode `drainReq` is 1 exactly while the occupancy is at or above the selected level.
- R5: While config bit 2 (direct-mode disable) is 0, `outValid` equals `wrReq` and `outData` equals `wrData` in the same cycle. Nothing is stored, `fifoStatus` reads 100, `drainReq` stays 0, and `rdReq` has no effect.
- R6: A write with `cfgWrEn` updates bit 7 (error interrupt enable) at any time. Bits 2 and 1:0 change only when `streamEn` is 0. Readback places `fifoStatus` in bits 5:3, and bit 6 reads 0.
- R7: When `streamEn` is 1 and `dirMode` is 10 (memory to memory), config bit 2 reads 1 from the next cycle on, and this takes priority over a software write in the same cycle.
- R8: In buffered mode, `wrReq` while full or `rdReq` while empty sets `errFlag` on the next edge. The flag stays set until `errClr`, and a new error event wins over a clear in the same cycle.
- R9: `errIrq` is 1 only while both `errFlag` and config bit 7 are 1.
- R10: Words leave in the order they were accepted. A write refused because the FIFO is full does not alter the stored words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| streamEn | input | 1 | Stream enable; locks mode and threshold fields |
| dirMode | input | 2 | Transfer direction, 10 = memory to memory |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 8 | Configuration write value |
| cfgRdData | output | 8 | Configuration readback including status |
| errClr | input | 1 | Clears the error flag |
| wrReq | input | 1 | Write one item from the producer side |
| wrData | input | WIDTH | Item to write |
| rdReq | input | 1 | Consume the head item (buffered mode) |
| outValid | output | 1 | Head item or pass-through item valid |
| outData | output | WIDTH | Head item or pass-through item |
| fifoStatus | output | 3 | Quarter-band level code |
| drainReq | output | 1 | Occupancy at or above threshold |
| errFlag | output | 1 | Sticky overflow/underflow flag |
| errIrq | output | 1 | Error flag gated by interrupt enable |

## Verification
The FIFO is filled one word at a time and then emptied, so every band code and both end codes appear. The drain request is checked against all four threshold settings at each fill depth, which separates a shifted threshold from a wrong compare. Direct mode is driven with data that differs from anything stored, which shows whether an item passed straight through or came out of storage. Overflow followed by a full readout shows whether a refused write damaged the contents. Locked writes and the memory-to-memory direction are applied while the stream is enabled, which separates the lock from the forced mode change.

// File: rtl/dmaFifoPkg.sv
package dmaFifoPkg;

  typedef struct packed {
    logic push;
    logic pop;
    logic bypass;
  } fifoStrobes_t;

  localparam logic [2:0] ST_EMPTY = 3'b100;
  localparam logic [2:0] ST_FULL  = 3'b101;
  localparam logic [1:0] DIR_M2M  = 2'b10;

endpackage

// File: rtl/fifoDatapath.sv
module fifoDatapath
  import dmaFifoPkg::*;
#(
  parameter int DEPTH = 4,
  parameter int WIDTH = 32,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobes_t     strobes,
  input  logic             wrReq,
  input  logic [WIDTH-1:0] wrData,
  output logic             outValid,
  output logic [WIDTH-1:0] outData,
  output logic [CW-1:0]    level
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wrPtr;
  logic [PW-1:0]    rdPtr;

  always_ff @(posedge clk) begin
    if (strobes.push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (strobes.push) wrPtr <= wrPtr + 1'b1;
      if (strobes.pop)  rdPtr <= rdPtr + 1'b1;
      case ({strobes.push, strobes.pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_comb begin
    if (strobes.bypass) begin
      outValid = wrReq;
      outData  = wrData;
    end else begin
      outValid = (level != '0);
      outData  = mem[rdPtr];
    end
  end

endmodule

// File: rtl/fifoControl.sv
module fifoControl
  import dmaFifoPkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int QUARTER = DEPTH / 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         streamEn,
  input  logic [1:0]   dirMode,
  input  logic         cfgWrEn,
  input  logic [7:0]   cfgWrData,
  input  logic         errClr,
  input  logic         wrReq,
  input  logic         rdReq,
  input  logic [CW-1:0] level,
  output fifoStrobes_t strobes,
  output logic [7:0]   cfgRdData,
  output logic [2:0]   fifoStatus,
  output logic         drainReq,
  output logic         errFlag,
  output logic         errIrq
);

  logic       irqEn;
  logic       dmDis;
  logic [1:0] thrSel;
  logic       isFull;
  logic       isEmpty;
  logic       errEvent;
  logic [CW-1:0] band;
  logic [CW-1:0] thrLevel;
  logic [3:0]    cfgUnused;

  assign cfgUnused = cfgWrData[6:3];

  assign isFull  = (level == CW'(DEPTH));
  assign isEmpty = (level == '0);

  always_comb begin
    strobes.bypass = !dmDis;
    strobes.push   = dmDis && wrReq && !isFull;
    strobes.pop    = dmDis && rdReq && !isEmpty;
  end

  assign errEvent = dmDis && ((wrReq && isFull) || (rdReq && isEmpty));

  // configuration register with lock and forced buffered mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqEn  <= 1'b0;
      dmDis  <= 1'b0;
      thrSel <= 2'b00;
    end else begin
      if (cfgWrEn) begin
        irqEn <= cfgWrData[7];
        if (!streamEn) begin
          dmDis  <= cfgWrData[2];
          thrSel <= cfgWrData[1:0];
        end
      end
      if (streamEn && dirMode == DIR_M2M) dmDis <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         errFlag <= 1'b0;
    else if (errEvent) errFlag <= 1'b1;
    else if (errClr)   errFlag <= 1'b0;
  end

  assign errIrq = errFlag & irqEn;

  // quarter band encoder
  assign band = level / CW'(QUARTER);

  always_comb begin
    if (!dmDis || isEmpty) fifoStatus = ST_EMPTY;
    else if (isFull)       fifoStatus = ST_FULL;
    else                   fifoStatus = {1'b0, band[1:0]};
  end

  assign thrLevel = CW'((32'(thrSel) + 32'd1) * QUARTER);
  assign drainReq = dmDis && (level >= thrLevel);

  assign cfgRdData = {irqEn, 1'b0, fifoStatus, dmDis, thrSel};

endmodule

// File: rtl/dmaFifo.sv
module dmaFifo
  import dmaFifoPkg::*;
#(
  parameter int DEPTH = 4,
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             streamEn,
  input  logic [1:0]       dirMode,
  input  logic             cfgWrEn,
  input  logic [7:0]       cfgWrData,
  output logic [7:0]       cfgRdData,
  input  logic             errClr,
  input  logic             wrReq,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdReq,
  output logic             outValid,
  output logic [WIDTH-1:0] outData,
  output logic [2:0]       fifoStatus,
  output logic             drainReq,
  output logic             errFlag,
  output logic             errIrq
);

  localparam int CW = $clog2(DEPTH + 1);

  fifoStrobes_t  strobes;
  logic [CW-1:0] level;

  fifoControl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .streamEn(streamEn), .dirMode(dirMode),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .errClr(errClr),
    .wrReq(wrReq), .rdReq(rdReq), .level(level), .strobes(strobes),
    .cfgRdData(cfgRdData), .fifoStatus(fifoStatus), .drainReq(drainReq),
    .errFlag(errFlag), .errIrq(errIrq)
  );

  fifoDatapath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrReq(wrReq),
    .wrData(wrData), .outValid(outValid), .outData(outData), .level(level)
  );

endmodule

// File: rtl/dmaFifoChk.sv
module dmaFifoChk (
  input logic       clk,
  input logic       rstN,
  input logic       streamEn,
  input logic [1:0] dirMode,
  input logic       cfgWrEn,
  input logic [7:0] cfgRdData,
  input logic       wrReq,
  input logic       outValid,
  input logic [2:0] fifoStatus,
  input logic       drainReq,
  input logic       errFlag
);

  // R3
  status_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoStatus[2] && fifoStatus[1]));

  // R8
  overflow_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdData[2] && wrReq && fifoStatus == 3'b101) |=> errFlag);

  // R6
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (streamEn && cfgWrEn && dirMode != 2'b10) |=> $stable(cfgRdData[2:0]));

  // R7
  force_buffered_chk: assert property (@(posedge clk) disable iff (!rstN)
    (streamEn && dirMode == 2'b10) |=> cfgRdData[2]);

  // R5
  direct_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgRdData[2] |-> (outValid == wrReq) && !drainReq && fifoStatus == 3'b100);

  // R4
  full_drain_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdData[2] && fifoStatus == 3'b101) |-> drainReq);

endmodule

bind dmaFifo dmaFifoChk u_chk (
  .clk(clk), .rstN(rstN), .streamEn(streamEn), .dirMode(dirMode),
  .cfgWrEn(cfgWrEn), .cfgRdData(cfgRdData), .wrReq(wrReq),
  .outValid(outValid), .fifoStatus(fifoStatus), .drainReq(drainReq),
  .errFlag(errFlag)
);

// File: tb/dmaFifo_tb.sv
module dmaFifo_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        streamEn;
  logic [1:0]  dirMode;
  logic        cfgWrEn;
  logic [7:0]  cfgWrData;
  logic [7:0]  cfgRdData;
  logic        errClr;
  logic        wrReq;
  logic [31:0] wrData;
  logic        rdReq;
  logic        outValid;
  logic [31:0] outData;
  logic [2:0]  fifoStatus;
  logic        drainReq;
  logic        errFlag;
  logic        errIrq;

  int nTests = 0;
  int nFail  = 0;

  always #2 clk = ~clk;

  dmaFifo u_dut (
    .clk(clk), .rstN(rstN), .streamEn(streamEn), .dirMode(dirMode),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .errClr(errClr), .wrReq(wrReq), .wrData(wrData), .rdReq(rdReq),
    .outValid(outValid), .outData(outData), .fifoStatus(fifoStatus),
    .drainReq(drainReq), .errFlag(errFlag), .errIrq(errIrq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FIFO FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    rstN = 1'b0; streamEn = 1'b0; dirMode = 2'b00; cfgWrEn = 1'b0;
    cfgWrData = '0; errClr = 1'b0; wrReq = 1'b0; wrData = '0; rdReq = 1'b0;
    tick(); tick();
    rstN = 1'b1;
    tick();
  endtask

  task automatic cfgWrite(input logic [7:0] v);
    cfgWrEn = 1'b1; cfgWrData = v;
    tick();
    cfgWrEn = 1'b0;
  endtask

  task automatic pushWord(input logic [31:0] d);
    wrReq = 1'b1; wrData = d;
    tick();
    wrReq = 1'b0;
  endtask

  task automatic popCheck(input string tag, input logic [31:0] exp);
    check(tag, outData, exp);
    rdReq = 1'b1;
    tick();
    rdReq = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    check("R1 cfg readback", 32'(cfgRdData), 32'h20);
    check("R1 status", 32'(fifoStatus), 32'h4);
    check("R1 errFlag", 32'(errFlag), 0);
    check("R1 errIrq", 32'(errIrq), 0);
    check("R1 drainReq", 32'(drainReq), 0);
  endtask

  task automatic testDirect();
    doReset();
    wrReq = 1'b1; wrData = 32'hA5A5_0001;
    #1;
    check("R5 outValid", 32'(outValid), 1);
    check("R5 outData", outData, 32'hA5A5_0001);
    tick();
    wrReq = 1'b0;
    #1;
    check("R5 outValid idle", 32'(outValid), 0);
    check("R5 status", 32'(fifoStatus), 32'h4);
    check("R5 drainReq", 32'(drainReq), 0);
    rdReq = 1'b1;
    tick();
    rdReq = 1'b0;
    check("R5 rdReq ignored errFlag", 32'(errFlag), 0);
  endtask

  task automatic testLevels();
    logic [2:0] expSt [5] = '{3'b100, 3'b001, 3'b010, 3'b011, 3'b101};
    doReset();
    cfgWrite(8'h05);
    check("R3 empty", 32'(fifoStatus), 32'h4);
    for (int k = 1; k <= 4; k++) begin
      pushWord(32'h1000 + 32'(k));
      check($sformatf("R2 status at %0d", k), 32'(fifoStatus), 32'(expSt[k]));
      check($sformatf("R4 drain thr=01 at %0d", k), 32'(drainReq), 32'(k >= 2));
    end
    check("R3 full code", 32'(fifoStatus), 32'h5);
    check("R3 full readback", 32'(cfgRdData[5:3]), 32'h5);
    for (int k = 1; k <= 4; k++) popCheck($sformatf("R10 order %0d", k), 32'h1000 + 32'(k));
    check("R3 empty after drain", 32'(fifoStatus), 32'h4);
  endtask

  task automatic testThresholds();
    for (int t = 0; t < 4; t++) begin
      doReset();
      cfgWrite(8'h04 | 8'(t));
      for (int k = 1; k <= 4; k++) begin
        pushWord(32'(k));
        check($sformatf("R4 thr=%0d level=%0d", t, k), 32'(drainReq), 32'(k >= t + 1));
      end
    end
  endtask

  task automatic testProtect();
    doReset();
    cfgWrite(8'h05);
    streamEn = 1'b1; dirMode = 2'b00;
    cfgWrite(8'h82);
    check("R6 locked write", 32'(cfgRdData), 32'hA5);
    streamEn = 1'b0;
    cfgWrite(8'h02);
    check("R6 unlocked write", 32'(cfgRdData), 32'h22);
  endtask

  task automatic testForce();
    doReset();
    check("R7 pre direct", 32'(cfgRdData[2]), 0);
    streamEn = 1'b1; dirMode = 2'b10;
    cfgWrEn = 1'b1; cfgWrData = 8'h00;
    tick();
    cfgWrEn = 1'b0;
    check("R7 forced buffered", 32'(cfgRdData[2]), 1);
    streamEn = 1'b0; dirMode = 2'b00;
  endtask

  task automatic testError();
    doReset();
    cfgWrite(8'h07);
    for (int k = 0; k < 4; k++) pushWord(32'hB000 + 32'(k));
    check("R8 no flag before overflow", 32'(errFlag), 0);
    pushWord(32'hDEAD_BEEF);
    check("R8 overflow flag", 32'(errFlag), 1);
    check("R9 irq gated off", 32'(errIrq), 0);
    cfgWrite(8'h87);
    check("R9 irq enabled", 32'(errIrq), 1);
    tick();
    check("R8 flag sticky", 32'(errFlag), 1);
    errClr = 1'b1; tick(); errClr = 1'b0;
    check("R8 cleared", 32'(errFlag), 0);
    check("R9 irq cleared", 32'(errIrq), 0);
    for (int k = 0; k < 4; k++) popCheck($sformatf("R10 after overflow %0d", k), 32'hB000 + 32'(k));
    rdReq = 1'b1; errClr = 1'b1;
    tick();
    rdReq = 1'b0; errClr = 1'b0;
    check("R8 underflow wins over clear", 32'(errFlag), 1);
  endtask

  initial begin
    #(200000 * 4);
    nFail++;
    $display("FIFO FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    testReset();
    testDirect();
    testLevels();
    testThresholds();
    testProtect();
    testForce();
    testError();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule